// File: doc/BRIEF.md
# Indirect Configuration Register Access Controller

This controller lets a host reach a bank of 256 configuration addresses of a pipelined quantum-gate emulator through one 32-bit write port and one 32-bit read port. Two strobes go with the ports: a write enable and a read enable. Every configuration write takes two host writes. The first write latches an 8-bit target address. The second write delivers the value for that address.

Addresses below 16 hold the initial qubit word of each of the 16 input lanes. Addresses with the top bit set select a gate input. Bits [6:4] of such an address name a pipeline column and bits [3:0] name a row. The stored 4-bit value tells the multiplexer in front of that gate which lane of the previous stage it takes.

To read, the host writes the number of an output-stage lane and then pulses the read enable. The host read port then holds that lane's final 32-bit value. The block also contains a free-running 16-bit linear feedback shift register. The gate logic uses it as its pseudo-random source for measurement.

Top module: `qge_host_ctrl`

## Requirements
- R1: While reset is asserted, the host read port is 0, all initial qubit words are 0, all gate selects are 0, the random output equals 16'hACE1, and the write phase is the address phase.
- R2: Each write strobe flips the write phase. The first write after reset is an address write, the second is a data write, and so on.
- R3: A data write to an address in 0..15 stores the whole 32-bit word as the initial qubit of that lane. The lane for address n is bits [32n+31:32n] of the initial qubit output.
- R4: A data write to address 1cccrrrr with row rrrr below 13 stores data bits [3:0] as the select of column ccc, gate rrrr. This select appears at bits [(13c+r)*4+3:(13c+r)*4] of the gate select output. Data bits [31:4] are ignored.
- R5: A data write to an address with row 13..15 in the select space, or to an address in 16..127, changes no register. It still flips the write phase.
- R6: A read strobe given in the data phase loads the host read port on the next clock edge. If the latched address is in 0..15, the port takes that lane's 32-bit result. The read also returns the write phase to the address phase.
- R7: A read strobe given in the data phase with a latched address of 16 or more loads 0. A read strobe given in the address phase leaves the host read port unchanged.
- R8: When the write and read strobes are high in the same cycle, the write is performed and the read is ignored.
- R9: The random output advances on every clock to {v[14:0], v[15]^v[13]^v[12]^v[10]} and is never zero.
- R10: An address write uses only bits [7:0] of the host word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wdata | input | 32 | Host write word (address or data) |
| host_wr | input | 1 | Write strobe, one pulse per host write |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Registered read result |
| lane_result_i | input | 512 | Output-stage qubit words of the 16 lanes, lane n at [32n+31:32n] |
| init_qubit_o | output | 512 | Initial qubit words of the 16 lanes |
| gate_sel_o | output | 416 | Gate input selects, 4 bits per gate, 13 gates per column, 8 columns |
| rand_o | output | 16 | Pseudo-random value for measurement |

## Verification
The hardest state to reach is a host sequence that leaves the write phase out of step with what the host intends. Examples are a read strobe during the address phase, a read that coincides with a write, and a data write aimed at a select row with no gate behind it.

Phase is not visible at the ports. The bench therefore tracks it in its own model, and then proves the tracking right by issuing a later write that must land as an address or as data. Random operation mixes include lone writes, reads in either phase and simultaneous strobes, so the phase drifts arbitrarily. Directed cases cover unmapped addresses, rows 13 to 15 and upper-bit masking.

// File: rtl/qge_host_pkg.sv
package qge_host_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int LANES     = 16;
  localparam int COLS      = 8;
  localparam int GATES     = 13;
  localparam int SEL_W     = 4;
  localparam int RAND_W    = 16;
  localparam logic [RAND_W-1:0] RAND_SEED = 16'hACE1;

  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} wphase_e;
endpackage

// File: rtl/qh_decode.sv
module qh_decode #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 16,
  parameter int COLS   = 8,
  parameter int GATES  = 13,
  localparam int ROW_W = $clog2(LANES),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              lane_hit,
  output logic              sel_hit,
  output logic [ROW_W-1:0]  row_idx,
  output logic [COL_W-1:0]  col_idx
);
  localparam logic [ADDR_W-1:0] LANE_LIM = ADDR_W'(LANES);
  localparam logic [ROW_W-1:0]  GATE_LIM = ROW_W'(GATES);

  always_comb begin
    row_idx  = addr[ROW_W-1:0];
    col_idx  = addr[ROW_W +: COL_W];
    lane_hit = (addr < LANE_LIM);
    sel_hit  = addr[ADDR_W-1] && (row_idx < GATE_LIM);
  end
endmodule

// File: rtl/qh_bank.sv
module qh_bank #(
  parameter int DATA_W = 32,
  parameter int LANES  = 16,
  parameter int COLS   = 8,
  parameter int GATES  = 13,
  parameter int SEL_W  = 4,
  localparam int ROW_W = $clog2(LANES),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         lane_hit,
  input  logic                         sel_hit,
  input  logic [ROW_W-1:0]             row_idx,
  input  logic [COL_W-1:0]             col_idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [LANES*DATA_W-1:0]      init_flat,
  output logic [COLS*GATES*SEL_W-1:0]  sel_flat
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DATA_W-1:0] q_q, q_d;
    logic              ce;
    always_comb begin
      ce  = wr_en && lane_hit && (row_idx == ROW_W'(i));
      q_d = ce ? wdata : q_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q <= '0;
      else        q_q <= q_d;
    end
    assign init_flat[i*DATA_W +: DATA_W] = q_q;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar g = 0; g < GATES; g++) begin : g_gate
      logic [SEL_W-1:0] s_q, s_d;
      logic             ce;
      always_comb begin
        ce  = wr_en && sel_hit && (col_idx == COL_W'(c)) && (row_idx == ROW_W'(g));
        s_d = ce ? wdata[SEL_W-1:0] : s_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
      end
      assign sel_flat[(c*GATES+g)*SEL_W +: SEL_W] = s_q;
    end
  end
endmodule

// File: rtl/qh_lfsr.sv
module qh_lfsr #(
  parameter int                RAND_W = 16,
  parameter logic [RAND_W-1:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [RAND_W-1:0] value
);
  logic [RAND_W-1:0] v_q, v_d;

  always_comb v_d = {v_q[RAND_W-2:0], v_q[15] ^ v_q[13] ^ v_q[12] ^ v_q[10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= SEED;
    else        v_q <= v_d;
  end

  assign value = v_q;
endmodule

// File: rtl/qge_host_ctrl.sv
module qge_host_ctrl
  import qge_host_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DATA_W-1:0]             host_wdata,
  input  logic                          host_wr,
  input  logic                          host_rd,
  output logic [DATA_W-1:0]             host_rdata,
  input  logic [LANES*DATA_W-1:0]       lane_result_i,
  output logic [LANES*DATA_W-1:0]       init_qubit_o,
  output logic [COLS*GATES*SEL_W-1:0]   gate_sel_o,
  output logic [RAND_W-1:0]             rand_o
);
  localparam int ROW_W = $clog2(LANES);
  localparam int COL_W = $clog2(COLS);

  logic rst_s0, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  wphase_e           phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              data_wr, rd_take;
  logic              lane_hit, sel_hit;
  logic [ROW_W-1:0]  row_idx;
  logic [COL_W-1:0]  col_idx;
  logic [DATA_W-1:0] lane_val;

  qh_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .COLS(COLS), .GATES(GATES)) u_dec (
    .addr(addr_q), .lane_hit(lane_hit), .sel_hit(sel_hit),
    .row_idx(row_idx), .col_idx(col_idx)
  );

  always_comb begin
    lane_val = '0;
    for (int i = 0; i < LANES; i++)
      if (row_idx == ROW_W'(i)) lane_val = lane_result_i[i*DATA_W +: DATA_W];
  end

  always_comb begin
    data_wr = host_wr && (phase_q == PH_DATA);
    rd_take = host_rd && !host_wr && (phase_q == PH_DATA);
    phase_d = phase_q;
    addr_d  = addr_q;
    rdata_d = rdata_q;
    if (host_wr) begin
      phase_d = (phase_q == PH_ADDR) ? PH_DATA : PH_ADDR;
      if (phase_q == PH_ADDR) addr_d = host_wdata[ADDR_W-1:0];
    end else if (rd_take) begin
      phase_d = PH_ADDR;
      rdata_d = lane_hit ? lane_val : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_ADDR;
      addr_q  <= '0;
      rdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      rdata_q <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;

  qh_bank #(.DATA_W(DATA_W), .LANES(LANES), .COLS(COLS), .GATES(GATES), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(data_wr), .lane_hit(lane_hit),
    .sel_hit(sel_hit), .row_idx(row_idx), .col_idx(col_idx), .wdata(host_wdata),
    .init_flat(init_qubit_o), .sel_flat(gate_sel_o)
  );

  qh_lfsr #(.RAND_W(RAND_W), .SEED(RAND_SEED)) u_rand (
    .clk(clk), .rst_n(rst_sync_n), .value(rand_o)
  );
endmodule

// File: rtl/qh_host_chk.sv
module qh_host_chk
  import qge_host_pkg::*;
(
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        host_wr,
  input logic                        host_rd,
  input logic                        phase,
  input logic [DATA_W-1:0]           rdata,
  input logic [LANES*DATA_W-1:0]     init_flat,
  input logic [COLS*GATES*SEL_W-1:0] sel_flat,
  input logic [RAND_W-1:0]           rnd
);
  p_phase_flip_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_wr |=> (phase != $past(phase)));

  p_no_store_outside_data_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(host_wr && phase) |=> ($stable(init_flat) && $stable(sel_flat)));

  p_read_rearms_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && !host_wr && phase) |=> !phase);

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(host_rd && !host_wr && phase) |=> $stable(rdata));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr && host_rd) |=> $stable(rdata));

  p_rand_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rnd != '0);

  p_rand_moves_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (rnd[RAND_W-1:1] == $past(rnd[RAND_W-2:0])));
endmodule

bind qge_host_ctrl qh_host_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .host_wr(host_wr), .host_rd(host_rd),
  .phase(phase_q), .rdata(host_rdata), .init_flat(init_qubit_o),
  .sel_flat(gate_sel_o), .rnd(rand_o)
);

// File: tb/qge_host_ctrl_tb.sv
module qge_host_ctrl_tb;
  import qge_host_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] host_wdata;
  logic host_wr, host_rd;
  logic [31:0] host_rdata;
  logic [LANES*DATA_W-1:0] lane_result_i;
  logic [LANES*DATA_W-1:0] init_qubit_o;
  logic [COLS*GATES*SEL_W-1:0] gate_sel_o;
  logic [15:0] rand_o;

  always #4 clk = ~clk;

  qge_host_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_wdata(host_wdata), .host_wr(host_wr),
    .host_rd(host_rd), .host_rdata(host_rdata), .lane_result_i(lane_result_i),
    .init_qubit_o(init_qubit_o), .gate_sel_o(gate_sel_o), .rand_o(rand_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] init_m [LANES];
  logic [3:0]  sel_m  [COLS][GATES];
  logic [31:0] lane_m [LANES];
  logic [31:0] rdata_m;
  logic [7:0]  addr_m;
  bit          phase_m;

  function automatic logic [15:0] rstep(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    bit ok = 1;
    for (int i = 0; i < LANES; i++)
      if (init_qubit_o[i*32 +: 32] !== init_m[i]) ok = 0;
    chk({tag, " init"}, {31'd0, ok}, 32'd1);
    ok = 1;
    for (int c = 0; c < COLS; c++)
      for (int g = 0; g < GATES; g++)
        if (gate_sel_o[(c*GATES+g)*4 +: 4] !== sel_m[c][g]) ok = 0;
    chk({tag, " sel"}, {31'd0, ok}, 32'd1);
    chk({tag, " rdata"}, host_rdata, rdata_m);
  endtask

  function automatic void model_wr(logic [31:0] w);
    if (!phase_m) begin
      addr_m = w[7:0];
      phase_m = 1;
    end else begin
      if (addr_m < 8'd16) init_m[addr_m[3:0]] = w;
      else if (addr_m[7] && addr_m[3:0] < 4'd13) sel_m[addr_m[6:4]][addr_m[3:0]] = w[3:0];
      phase_m = 0;
    end
  endfunction

  task automatic op(bit wr, bit rd, logic [31:0] w, string tag);
    @(negedge clk);
    host_wdata = w; host_wr = wr; host_rd = rd;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    if (wr) model_wr(w);
    else if (rd && phase_m) begin
      rdata_m = (addr_m < 8'd16) ? lane_m[addr_m[3:0]] : 32'd0;
      phase_m = 0;
    end
    chk_state(tag);
  endtask

  task automatic set_lanes();
    for (int i = 0; i < LANES; i++) begin
      lane_m[i] = $urandom;
      lane_result_i[i*32 +: 32] = lane_m[i];
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5EED));
    rst_n = 0; host_wdata = 0; host_wr = 0; host_rd = 0; lane_result_i = '0;
    for (int i = 0; i < LANES; i++) begin init_m[i] = 0; lane_m[i] = 0; end
    for (int c = 0; c < COLS; c++) for (int g = 0; g < GATES; g++) sel_m[c][g] = 0;
    rdata_m = 0; addr_m = 0; phase_m = 0;
    set_lanes();
    repeat (3) @(negedge clk);
    chk_state("R1 reset");
    chk("R1 rand seed", {16'd0, rand_o}, 32'h0000ACE1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 / R3: address word with junk upper bits
    op(1, 0, 32'hFFFF_FF05, "R10 addr");
    op(1, 0, 32'hDEAD_BEEF, "R3 lane5");
    // R4: select column 2 gate 7, upper data ignored
    op(1, 0, 32'h0000_00A7, "R2 addr");
    op(1, 0, 32'h0ABC_DEF9, "R4 sel");
    // R5: rows 13..15 and unmapped space
    op(1, 0, 32'h0000_009D, "R5 addr");
    op(1, 0, 32'h0000_000F, "R5 row13");
    op(1, 0, 32'h0000_00FF, "R5 addr");
    op(1, 0, 32'h0000_0003, "R5 row15");
    op(1, 0, 32'h0000_0040, "R5 addr");
    op(1, 0, 32'h1234_5678, "R5 unmapped");
    // R6: read lane 9
    op(1, 0, 32'h0000_0009, "R6 addr");
    op(0, 1, 32'h0, "R6 read");
    // R7: read in address phase is ignored, then unmapped read gives 0
    op(0, 1, 32'h0, "R7 idle read");
    op(1, 0, 32'h0000_0085, "R7 addr");
    op(0, 1, 32'h0, "R7 sel read");
    // R8: write and read together
    op(1, 0, 32'h0000_0002, "R8 addr");
    op(1, 1, 32'hCAFE_0002, "R8 both");
    op(1, 0, 32'h0000_0003, "R2 after R8");
    op(1, 0, 32'h0BAD_F00D, "R3 lane3");

    // R9: stepping and nonzero
    for (int k = 0; k < 40; k++) begin
      v = rand_o;
      @(negedge clk);
      chk("R9 step", {16'd0, rand_o}, {16'd0, rstep(v)});
      chk("R9 nonzero", {31'd0, rand_o != 16'd0}, 32'd1);
    end

    // random mix
    for (int k = 0; k < 600; k++) begin
      int kind = $urandom_range(0, 9);
      logic [31:0] w = $urandom;
      if (k % 50 == 0) set_lanes();
      if (!phase_m) begin
        case ($urandom_range(0, 2))
          0: w[7:0] = {4'd0, w[3:0]};
          1: w[7] = 1'b1;
          default: ;
        endcase
      end
      if (kind < 6)      op(1, 0, w, "R2 rnd write");
      else if (kind < 9) op(0, 1, w, "R6 rnd read");
      else               op(1, 1, w, "R8 rnd both");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule